// File: doc/BRIEF.md
# I2C Single-Master Byte Controller

This block is the master side of an I2C bus. A host issues one operation at a time: a Start, a Repeated Start, a Stop, a byte write, a byte receive, or the acknowledge bit that follows a received byte. The controller then runs the SCL and SDA lines through open-drain enables. A 1 on an enable pulls that line low and a 0 releases it. The controller reads both lines back through its sample inputs. SCL timing comes from a reload counter. The host programs the reload value.

Completion of every operation raises one shared interrupt flag. The flag stays set until the host clears it. Two status bits record whether this master holds the bus: one for Start seen and one for Stop seen. No command is queued. A buffer write made while an operation is running is discarded and raises a sticky write-collision flag. While the controller releases SDA during a data bit, it compares the line with what it meant to send. A mismatch raises a bus-collision flag and abandons the transfer.

Top module: `i2c_master_byte`

## Requirements
- R1: After reset both line enables are 0 (released), `busy` is 0, and `st_start`, `st_stop`, `irq`, `wcol` and `bcol` are all 0.
- R2: A Start request (`go` with `op`=0) is taken only when the bus is free, meaning `st_stop`=1 or both status bits are 0. The controller pulls SDA while SCL is released, then pulls SCL one half-period later. On completion `st_start`=1, `st_stop`=0 and `irq`=1. The two status bits are never 1 together.
- R3: A buffer write (`wr_en`) while `st_start`=1 sends `wr_data` MSB first in eight SCL clocks. SDA is released on a ninth clock, and SDA sampled during that clock is stored in `ack_stat` (1 = not acknowledged). Completion sets `irq`.
- R4: A receive request (`op`=3) keeps SDA released for eight SCL clocks. It samples SDA at the end of each high phase, MSB first, and places the byte on `rx_data`. Completion sets `irq`.
- R5: An acknowledge request (`op`=4) drives one SCL clock with SDA pulled when `ack_val`=0 (ACK) and released when `ack_val`=1 (NACK). Completion sets `irq`.
- R6: A Repeated Start request (`op`=1) releases SDA, releases SCL, pulls SDA while SCL is high, and then pulls SCL, one half-period per step. It ends with `st_start`=1 and `irq`=1.
- R7: A Stop request (`op`=2) pulls SDA with SCL low, releases SCL, and then releases SDA while SCL is high, one half-period per step. It ends with both lines released, `st_stop`=1, `st_start`=0 and `irq`=1.
- R8: Every SCL half-period and protocol step lasts `baud_reload`+1 clocks. The count holds while SCL is released but sampled low, so a slave can stretch the clock.
- R9: A buffer write while `busy`=1, or in the same cycle as a `go` request, does not load the buffer and starts no transfer. It sets `wcol`, which stays 1 until `wcol_clr`.
- R10: `irq` stays 1 after it is set until the host pulses `irq_clr`.
- R11: If SDA reads low at the end of the high phase of a data bit that the controller released during a write, `bcol` and `irq` go to 1. Both lines are released, `busy` drops and `st_start` clears. `irq_clr` also clears `bcol`.
- R12: Taking `en` low stops any operation, releases both lines and clears `st_start` and `st_stop`.
- R13: Repeated Start, Stop, receive, acknowledge and buffer-write requests are ignored unless `st_start`=1. A Start request is ignored while `st_start`=1 and `st_stop`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Module enable |
| go | input | 1 | One-cycle request for the operation in `op` |
| op | input | 3 | 0 Start, 1 Repeated Start, 2 Stop, 3 receive, 4 acknowledge |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Byte to transmit |
| ack_val | input | 1 | Acknowledge bit to send: 0 ACK, 1 NACK |
| baud_reload | input | RELOAD_W | Half-period reload value |
| irq_clr | input | 1 | Clears `irq` and `bcol` |
| wcol_clr | input | 1 | Clears `wcol` |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Last received byte |
| ack_stat | output | 1 | Acknowledge seen after last write, 1 = NACK |
| busy | output | 1 | An operation is running |
| st_start | output | 1 | Start seen, this master holds the bus |
| st_stop | output | 1 | Stop seen |
| irq | output | 1 | Sticky event flag |
| wcol | output | 1 | Sticky write-collision flag |
| bcol | output | 1 | Sticky bus-collision flag |

## Verification
The hardest conditions to produce from the ports are a stretched SCL high phase and a lost SDA bit, because both need another device on the wires. The bench models the bus as wired-AND lines joined to a small slave model. To stretch, the model is armed with a number of cycles and holds SCL low after the master releases it; the bench then confirms the operation grew by exactly that many clocks while the SCL high time did not change. To force a collision, a bench-driven pull-down holds SDA low while the controller sends 0xFF, so the first released data bit reads back low.

// File: rtl/i2c_master_byte.sv
module i2c_master_byte #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                go,
  input  logic [2:0]          op,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic                ack_val,
  input  logic [RELOAD_W-1:0] baud_reload,
  input  logic                irq_clr,
  input  logic                wcol_clr,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                scl_oe,
  output logic                sda_oe,
  output logic [7:0]          rx_data,
  output logic                ack_stat,
  output logic                busy,
  output logic                st_start,
  output logic                st_stop,
  output logic                irq,
  output logic                wcol,
  output logic                bcol
);
  localparam logic [2:0] OP_START = 3'd0, OP_RSTART = 3'd1, OP_STOP = 3'd2,
                         OP_RECV = 3'd3, OP_ACK = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_RSTART, S_STOP, S_BITS} state_t;

  state_t              st;
  logic [1:0]          step;
  logic                half;
  logic [3:0]          bitcnt, nbits;
  logic                is_wr, is_ack;
  logic [7:0]          shreg;
  logic [RELOAD_W-1:0] cnt;

  logic stretch, tick, bus_free, launch_wr, lost_bit;

  assign busy      = (st != S_IDLE);
  assign stretch   = !scl_oe && !scl_i;
  assign tick      = busy && (cnt == '0) && !stretch;
  assign bus_free  = st_stop || !st_start;
  assign launch_wr = wr_en && !go && st_start;
  assign lost_bit  = is_wr && (bitcnt < 4'd8) && !sda_oe && !sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  step <= '0;  half <= 1'b0;  bitcnt <= '0;  nbits <= '0;
      is_wr <= 1'b0;  is_ack <= 1'b0;  shreg <= '0;  cnt <= '0;
      scl_oe <= 1'b0;  sda_oe <= 1'b0;  rx_data <= '0;  ack_stat <= 1'b0;
      st_start <= 1'b0;  st_stop <= 1'b0;  irq <= 1'b0;  wcol <= 1'b0;  bcol <= 1'b0;
    end else if (!en) begin
      st <= S_IDLE;  step <= '0;  half <= 1'b0;  bitcnt <= '0;
      scl_oe <= 1'b0;  sda_oe <= 1'b0;  st_start <= 1'b0;  st_stop <= 1'b0;
    end else begin
      if (irq_clr) begin
        irq  <= 1'b0;
        bcol <= 1'b0;
      end
      if (wcol_clr) wcol <= 1'b0;
      if (wr_en && (busy || go)) wcol <= 1'b1;

      if (tick) cnt <= baud_reload;
      else if (!stretch) cnt <= cnt - RELOAD_W'(1);

      case (st)
        S_IDLE: begin
          cnt <= baud_reload;  step <= '0;  half <= 1'b0;  bitcnt <= '0;
          if (go) begin
            case (op)
              OP_START:  if (bus_free) begin st <= S_START;  sda_oe <= 1'b1; end
              OP_RSTART: if (st_start) begin st <= S_RSTART; sda_oe <= 1'b0; end
              OP_STOP:   if (st_start) begin st <= S_STOP;   sda_oe <= 1'b1; end
              OP_RECV: if (st_start) begin
                st <= S_BITS;  is_wr <= 1'b0;  is_ack <= 1'b0;  nbits <= 4'd8;  sda_oe <= 1'b0;
              end
              OP_ACK: if (st_start) begin
                st <= S_BITS;  is_wr <= 1'b0;  is_ack <= 1'b1;  nbits <= 4'd1;  sda_oe <= !ack_val;
              end
              default: ;
            endcase
          end else if (launch_wr) begin
            st <= S_BITS;  is_wr <= 1'b1;  is_ack <= 1'b0;  nbits <= 4'd9;
            shreg <= wr_data;  sda_oe <= !wr_data[7];
          end
        end

        S_START: if (tick) begin
          scl_oe <= 1'b1;  st <= S_IDLE;  st_start <= 1'b1;  st_stop <= 1'b0;  irq <= 1'b1;
        end

        S_RSTART: if (tick) begin
          step <= step + 2'd1;
          case (step)
            2'd0:    scl_oe <= 1'b0;
            2'd1:    sda_oe <= 1'b1;
            default: begin scl_oe <= 1'b1; st <= S_IDLE; st_start <= 1'b1; irq <= 1'b1; end
          endcase
        end

        S_STOP: if (tick) begin
          step <= step + 2'd1;
          case (step)
            2'd0:    scl_oe <= 1'b0;
            2'd1:    sda_oe <= 1'b0;
            default: begin st <= S_IDLE; st_stop <= 1'b1; st_start <= 1'b0; irq <= 1'b1; end
          endcase
        end

        S_BITS: if (tick) begin
          if (!half) begin
            half   <= 1'b1;
            scl_oe <= 1'b0;
          end else if (lost_bit) begin
            st <= S_IDLE;  half <= 1'b0;  sda_oe <= 1'b0;
            bcol <= 1'b1;  irq <= 1'b1;  st_start <= 1'b0;
          end else begin
            half   <= 1'b0;
            scl_oe <= 1'b1;
            bitcnt <= bitcnt + 4'd1;
            if (is_wr && bitcnt == 4'd8) ack_stat <= sda_i;
            if (!is_wr && !is_ack) shreg <= {shreg[6:0], sda_i};
            if (bitcnt == nbits - 4'd1) begin
              st <= S_IDLE;  irq <= 1'b1;  sda_oe <= 1'b0;
              if (!is_wr && !is_ack) rx_data <= {shreg[6:0], sda_i};
            end else if (is_wr) begin
              sda_oe <= (bitcnt == 4'd7) ? 1'b0 : !shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
            end
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_master_byte_chk.sv
module i2c_master_byte_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic go,
  input logic wr_en,
  input logic irq_clr,
  input logic busy,
  input logic scl_oe,
  input logic sda_oe,
  input logic st_start,
  input logic st_stop,
  input logic irq,
  input logic wcol,
  input logic bcol
);
  a_r2_start_pulls_sda: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && !scl_oe) |-> sda_oe);

  a_r2_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_start && st_stop));

  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_stop) |-> (!sda_oe && !scl_oe));

  a_r9_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && busy) |=> wcol);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  a_r11_collision_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol) |-> (!busy && !sda_oe && !scl_oe && irq));

  a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !st_start && !st_stop && !scl_oe && !sda_oe));

  a_r13_write_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !st_start && wr_en && !go) |=> !busy);
endmodule

bind i2c_master_byte i2c_master_byte_chk u_chk (.*);

// File: tb/i2c_master_byte_bench.sv
`timescale 1ns/1ps
module i2c_master_byte_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, en = 1'b1, go = 1'b0, wr_en = 1'b0, ack_val = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [6:0] reload = 7'd3;
  logic       irq_clr = 1'b0, wcol_clr = 1'b0, force_low = 1'b0;
  logic       scl_i, sda_i, scl_oe, sda_oe, ack_stat, busy, st_start, st_stop, irq, wcol, bcol;
  logic [7:0] rx_data;

  logic [1:0] s_mode = 2'd0;
  logic [7:0] s_byte = 8'h00;
  logic       s_ackbit = 1'b0;
  logic [7:0] stretch_n = 8'd0;
  logic [3:0] s_cnt = 4'd0;
  logic       s_prev = 1'b1;
  logic [8:0] s_cap = 9'd0;
  logic [7:0] s_hold = 8'd0;
  logic [3:0] nfall;
  logic       s_low;

  assign scl_i = !(scl_oe || (s_hold != 8'd0));
  assign nfall = s_cnt + {3'b000, (s_prev && !scl_i)};
  assign s_low = (s_mode == 2'd1 && nfall == 4'd8 && !s_ackbit) ||
                 (s_mode == 2'd2 && nfall < 4'd8 && !s_byte[3'd7 - nfall[2:0]]);
  assign sda_i = !(sda_oe || s_low || force_low);

  always @(posedge clk) begin
    if (go || wr_en) begin
      s_cnt <= 4'd0;  s_cap <= 9'd0;  s_prev <= scl_i;  s_hold <= stretch_n;
    end else begin
      s_prev <= scl_i;
      if (s_prev && !scl_i) s_cnt <= s_cnt + 4'd1;
      if (!s_prev && scl_i) s_cap <= {s_cap[7:0], sda_i};
      if (!scl_oe && s_hold != 8'd0) s_hold <= s_hold - 8'd1;
    end
  end

  i2c_master_byte u_i2c_master_byte (
    .clk(clk), .rst_n(rst_n), .en(en), .go(go), .op(op), .wr_en(wr_en), .wr_data(wr_data),
    .ack_val(ack_val), .baud_reload(reload), .irq_clr(irq_clr), .wcol_clr(wcol_clr),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
    .ack_stat(ack_stat), .busy(busy), .st_start(st_start), .st_stop(st_stop),
    .irq(irq), .wcol(wcol), .bcol(bcol));

  // {receive, ack bit, data}
  localparam logic [9:0] VEC [6] = '{10'h0A5, 10'h13C, 10'h296, 10'h301, 10'h080, 10'h3FF};

  int checks = 0, errors = 0, blen = 0, hcnt = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle;
    blen = 0;  hcnt = 0;
    while (busy && blen < 5000) begin
      blen++;
      if (scl_i) hcnt++;
      @(negedge clk);
    end
  endtask

  task automatic issue(input logic [2:0] o);
    @(negedge clk);  op = o;  go = 1'b1;
    @(negedge clk);  go = 1'b0;
    wait_idle();
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);  wr_data = d;  wr_en = 1'b1;
    @(negedge clk);  wr_en = 1'b0;
    wait_idle();
  endtask

  task automatic clear_irq;
    @(negedge clk);  irq_clr = 1'b1;
    @(negedge clk);  irq_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;  errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "scl_oe", scl_oe, 0);   chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "busy", busy, 0);       chk("R1", "st_start", st_start, 0);
    chk("R1", "st_stop", st_stop, 0); chk("R1", "irq", irq, 0);
    chk("R1", "wcol", wcol, 0);       chk("R1", "bcol", bcol, 0);

    issue(3'd2);
    chk("R13", "stop without bus runs", blen, 0);
    write_byte(8'h55);
    chk("R13", "write without bus runs", blen, 0);
    chk("R13", "wcol after ignored write", wcol, 0);

    issue(3'd0);
    chk("R8", "start length", blen, 4);
    chk("R2", "st_start", st_start, 1);  chk("R2", "st_stop", st_stop, 0);
    chk("R2", "irq", irq, 1);
    chk("R2", "lines pulled", {scl_oe, sda_oe}, 2'b11);
    issue(3'd0);
    chk("R13", "start while held runs", blen, 0);
    clear_irq();
    chk("R10", "irq cleared", irq, 0);

    for (int i = 0; i < 6; i++) begin
      automatic logic [9:0] v = VEC[i];
      if (!v[9]) begin
        s_mode = 2'd1;  s_ackbit = v[8];
        write_byte(v[7:0]);
        chk("R3", "bits on bus", s_cap, {v[7:0], v[8]});
        chk("R3", "ack_stat", ack_stat, v[8]);
        chk("R3", "irq", irq, 1);
        chk("R8", "write length", blen, 72);
        chk("R8", "scl high clocks", hcnt, 36);
      end else begin
        s_mode = 2'd2;  s_byte = v[7:0];
        issue(3'd3);
        chk("R4", "rx_data", rx_data, v[7:0]);
        chk("R4", "irq", irq, 1);
        chk("R8", "receive length", blen, 64);
        clear_irq();
        s_mode = 2'd0;  ack_val = v[8];
        issue(3'd4);
        chk("R5", "ack bit on bus", s_cap[0], v[8]);
        chk("R5", "irq", irq, 1);
        chk("R8", "ack length", blen, 8);
      end
      clear_irq();
    end

    issue(3'd1);
    chk("R6", "st_start", st_start, 1);  chk("R6", "irq", irq, 1);
    chk("R6", "length", blen, 12);
    clear_irq();

    s_mode = 2'd1;  s_ackbit = 1'b0;  stretch_n = 8'd5;
    write_byte(8'hC3);
    stretch_n = 8'd0;
    chk("R8", "stretched length", blen, 77);
    chk("R8", "stretched scl high clocks", hcnt, 36);
    chk("R3", "bits under stretch", s_cap, {8'hC3, 1'b0});

    reload = 7'd0;
    write_byte(8'h5A);
    chk("R8", "reload 0 length", blen, 18);
    chk("R3", "bits at reload 0", s_cap, {8'h5A, 1'b0});
    reload = 7'd3;
    clear_irq();

    @(negedge clk);  op = 3'd1;  go = 1'b1;
    @(negedge clk);  go = 1'b0;  wr_data = 8'hAA;  wr_en = 1'b1;
    @(negedge clk);  wr_en = 1'b0;
    chk("R9", "wcol on busy write", wcol, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9", "dropped write started", busy, 0);
    repeat (10) @(negedge clk);
    chk("R9", "wcol sticky", wcol, 1);
    chk("R10", "irq sticky", irq, 1);
    @(negedge clk);  wcol_clr = 1'b1;
    @(negedge clk);  wcol_clr = 1'b0;
    chk("R9", "wcol cleared", wcol, 0);
    clear_irq();

    issue(3'd2);
    chk("R7", "st_stop", st_stop, 1);  chk("R7", "st_start", st_start, 0);
    chk("R7", "lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R7", "irq", irq, 1);  chk("R7", "length", blen, 12);
    clear_irq();

    issue(3'd0);
    chk("R2", "start after stop length", blen, 4);
    chk("R2", "st_stop after start", st_stop, 0);
    clear_irq();

    s_mode = 2'd0;  force_low = 1'b1;
    write_byte(8'hFF);
    force_low = 1'b0;
    chk("R11", "bcol", bcol, 1);  chk("R11", "irq", irq, 1);
    chk("R11", "st_start", st_start, 0);
    chk("R11", "lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R11", "abort point", blen, 8);
    clear_irq();
    chk("R11", "bcol cleared", bcol, 0);

    issue(3'd0);
    issue(3'd2);
    @(negedge clk);  en = 1'b0;
    @(negedge clk);  en = 1'b1;
    chk("R12", "st_stop after disable", st_stop, 0);

    issue(3'd0);
    @(negedge clk);  wr_data = 8'h0F;  wr_en = 1'b1;
    @(negedge clk);  wr_en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12", "busy before disable", busy, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R12", "busy", busy, 0);  chk("R12", "st_start", st_start, 0);
    chk("R12", "lines released", {scl_oe, sda_oe}, 2'b00);
    en = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule